// File: doc/BRIEF.md
# Pipeline Interlock and Forwarding Unit

This block is the purely combinational hazard control for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It reads a compact instruction descriptor from each pipeline register. The descriptor holds an operation class, two source register numbers and a destination register number. From these it decides whether the decode-stage instruction must be held back. It also picks the data source for each forwarding multiplexer in the datapath.

When `stall` is high, the surrounding pipeline must keep the PC and the fetch/decode register unchanged and load a bubble into the decode/execute register, with all its control bits cleared. The block looks at the new contents again on the next cycle. Three select outputs steer the forwarding multiplexers: the two ALU operands in the execute stage and the store-data input of data memory in the memory stage.

The parameter `BYPASS` chooses between two variants. The first forwards fully and stalls only for a load followed at once by a consumer. The second is a pure interlock that never forwards and instead waits until the producer is in writeback. The register file writes in the first half of a cycle, so a producer in writeback never needs a stall or an operand bypass.

Top module: `hz_ctrl`

## Requirements
- R1: Operation class encoding is 2'b00 bubble, 2'b01 ALU (reads both sources, writes rd), 2'b10 load (reads source 1, writes rd), 2'b11 store (reads source 1 as address and source 2 as data, writes nothing). With BYPASS=1, `stall` is high exactly when decode/execute holds a load whose destination matches either of the following: fetch/decode source 1 of any non-bubble instruction, or fetch/decode source 2 of an ALU instruction. A store that needs the loaded value only as its data does not stall.
- R2: With BYPASS=0, `stall` is high when any source that the fetch/decode instruction reads matches the live destination in decode/execute or in execute/memory.
- R3: With BYPASS=1, `fwd_a` is 0 when the source 1 read by the decode/execute instruction matches the destination of an ALU instruction in execute/memory. Otherwise it is 1 when that source matches a live destination in memory/writeback. Otherwise it is 2 (register file). The execute/memory match wins over the memory/writeback match.
- R4: With BYPASS=1, `fwd_b` follows the same codes and priority for source 2, for ALU and store instructions in decode/execute.
- R5: With BYPASS=1, `fwd_st` is 1 when execute/memory holds a store whose source 2 matches a live destination in memory/writeback. The memory address is never forwarded.
- R6: Register 0, bubbles and stores never count as a destination for a match, so they cause no stall and no forward.
- R7: With BYPASS=0, `fwd_a` and `fwd_b` stay at 2 and `fwd_st` stays at 0.
- R8: With BYPASS=1, in a pipeline that obeys `stall`, each load-use dependence costs exactly one stall cycle, and `stall` is never high on two cycles in a row.
- R9: A destination held in memory/writeback never causes a stall in either mode. When all stages hold bubbles, the outputs are stall 0, selects 2 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fd_op | input | 2 | Operation class in fetch/decode |
| fd_rs1 | input | REG_W | Source 1 in fetch/decode |
| fd_rs2 | input | REG_W | Source 2 in fetch/decode |
| dx_op | input | 2 | Operation class in decode/execute |
| dx_rs1 | input | REG_W | Source 1 in decode/execute |
| dx_rs2 | input | REG_W | Source 2 in decode/execute |
| dx_rd | input | REG_W | Destination in decode/execute |
| xm_op | input | 2 | Operation class in execute/memory |
| xm_rs2 | input | REG_W | Store-data source in execute/memory |
| xm_rd | input | REG_W | Destination in execute/memory |
| mw_op | input | 2 | Operation class in memory/writeback |
| mw_rd | input | REG_W | Destination in memory/writeback |
| stall | output | 1 | Hold PC and fetch/decode, insert bubble into decode/execute |
| fwd_a | output | 2 | ALU operand A select: 0 execute/memory, 1 memory/writeback, 2 register file |
| fwd_b | output | 2 | ALU operand B select, same codes |
| fwd_st | output | 1 | Store data taken from memory/writeback when 1 |

## Verification
A load followed at once by a store of the loaded value must make no stall on one cycle. Two cycles later, with the load in writeback and the store in the memory stage, it must raise the store-data bypass. The reverse case, where a stall is raised while operand forwarding for the older instruction is active in the same cycle, is also exercised. The bench provokes both with directed instruction pairs and then with a stream of register numbers limited to r0 to r3, which makes dependences dense. A behavioural pipeline in the bench advances on its own predicted stall and compares all four outputs on every cycle. It also counts load-use pairs in retirement order and compares that count with the stall cycles the block raised.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam logic [1:0] OP_NOP = 2'b00;
  localparam logic [1:0] OP_ALU = 2'b01;
  localparam logic [1:0] OP_LD  = 2'b10;
  localparam logic [1:0] OP_ST  = 2'b11;

  localparam logic [1:0] SEL_XM = 2'd0;
  localparam logic [1:0] SEL_MW = 2'd1;
  localparam logic [1:0] SEL_RF = 2'd2;

  function automatic logic writes_rd(input logic [1:0] op);
    return (op == OP_ALU) || (op == OP_LD);
  endfunction

  function automatic logic reads_src1(input logic [1:0] op);
    return op != OP_NOP;
  endfunction

  function automatic logic reads_src2(input logic [1:0] op);
    return (op == OP_ALU) || (op == OP_ST);
  endfunction
endpackage

// File: rtl/hz_dest_cmp.sv
module hz_dest_cmp #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             src_used,
  input  logic [REG_W-1:0] dst,
  input  logic             dst_live,
  output logic             hit
);
  always_comb begin
    hit = src_used && dst_live && (dst != '0) && (src == dst);
  end
endmodule

// File: rtl/hz_opnd_sel.sv
module hz_opnd_sel
  import hz_pkg::*;
#(
  parameter bit BYPASS = 1'b1
) (
  input  logic       hit_xm,
  input  logic       hit_mw,
  output logic [1:0] sel
);
  generate
    if (BYPASS) begin : g_fwd
      always_comb begin
        if (hit_xm)      sel = SEL_XM;
        else if (hit_mw) sel = SEL_MW;
        else             sel = SEL_RF;
      end
    end else begin : g_lock
      logic unused_hits;
      always_comb begin
        unused_hits = hit_xm ^ hit_mw;
        sel         = SEL_RF;
      end
    end
  endgenerate
endmodule

// File: rtl/hz_stall.sv
module hz_stall
  import hz_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter bit BYPASS = 1'b1
) (
  input  logic [1:0]       fd_op,
  input  logic [REG_W-1:0] fd_rs1,
  input  logic [REG_W-1:0] fd_rs2,
  input  logic [1:0]       dx_op,
  input  logic [REG_W-1:0] dx_rd,
  input  logic [1:0]       xm_op,
  input  logic [REG_W-1:0] xm_rd,
  output logic             stall
);
  localparam int NPROD = 2;

  logic [1:0]       prod_op [NPROD];
  logic [REG_W-1:0] prod_rd [NPROD];
  logic [NPROD-1:0] hit_s1, hit_s2;

  always_comb begin
    prod_op[0] = dx_op;
    prod_rd[0] = dx_rd;
    prod_op[1] = xm_op;
    prod_rd[1] = xm_rd;
  end

  for (genvar p = 0; p < NPROD; p++) begin : g_prod
    hz_dest_cmp #(.REG_W(REG_W)) u_cmp_s1 (
      .src(fd_rs1), .src_used(reads_src1(fd_op)),
      .dst(prod_rd[p]), .dst_live(writes_rd(prod_op[p])), .hit(hit_s1[p]));
    hz_dest_cmp #(.REG_W(REG_W)) u_cmp_s2 (
      .src(fd_rs2), .src_used(reads_src2(fd_op)),
      .dst(prod_rd[p]), .dst_live(writes_rd(prod_op[p])), .hit(hit_s2[p]));
  end

  generate
    if (BYPASS) begin : g_load_use
      always_comb begin
        stall = (dx_op == OP_LD) &&
                (hit_s1[0] || (hit_s2[0] && (fd_op != OP_ST)));
      end
    end else begin : g_interlock
      always_comb begin
        stall = (|hit_s1) || (|hit_s2);
      end
    end
  endgenerate
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter bit BYPASS = 1'b1
) (
  input  logic [1:0]       fd_op,
  input  logic [REG_W-1:0] fd_rs1,
  input  logic [REG_W-1:0] fd_rs2,
  input  logic [1:0]       dx_op,
  input  logic [REG_W-1:0] dx_rs1,
  input  logic [REG_W-1:0] dx_rs2,
  input  logic [REG_W-1:0] dx_rd,
  input  logic [1:0]       xm_op,
  input  logic [REG_W-1:0] xm_rs2,
  input  logic [REG_W-1:0] xm_rd,
  input  logic [1:0]       mw_op,
  input  logic [REG_W-1:0] mw_rd,
  output logic             stall,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             fwd_st
);
  localparam int NOPND = 2;

  logic [REG_W-1:0] opnd_src  [NOPND];
  logic             opnd_used [NOPND];
  logic [1:0]       opnd_sel  [NOPND];
  logic [NOPND-1:0] hit_xm, hit_mw;
  logic             xm_result_ready, mw_live, st_hit;

  hz_stall #(.REG_W(REG_W), .BYPASS(BYPASS)) u_stall (
    .fd_op(fd_op), .fd_rs1(fd_rs1), .fd_rs2(fd_rs2),
    .dx_op(dx_op), .dx_rd(dx_rd),
    .xm_op(xm_op), .xm_rd(xm_rd),
    .stall(stall));

  // A load in execute/memory has only its address, not its data.
  always_comb begin
    xm_result_ready = (xm_op == OP_ALU);
    mw_live         = writes_rd(mw_op);
    opnd_src[0]     = dx_rs1;
    opnd_used[0]    = reads_src1(dx_op);
    opnd_src[1]     = dx_rs2;
    opnd_used[1]    = reads_src2(dx_op);
  end

  for (genvar k = 0; k < NOPND; k++) begin : g_opnd
    hz_dest_cmp #(.REG_W(REG_W)) u_cmp_xm (
      .src(opnd_src[k]), .src_used(opnd_used[k]),
      .dst(xm_rd), .dst_live(xm_result_ready), .hit(hit_xm[k]));
    hz_dest_cmp #(.REG_W(REG_W)) u_cmp_mw (
      .src(opnd_src[k]), .src_used(opnd_used[k]),
      .dst(mw_rd), .dst_live(mw_live), .hit(hit_mw[k]));
    hz_opnd_sel #(.BYPASS(BYPASS)) u_sel (
      .hit_xm(hit_xm[k]), .hit_mw(hit_mw[k]), .sel(opnd_sel[k]));
  end

  hz_dest_cmp #(.REG_W(REG_W)) u_cmp_st (
    .src(xm_rs2), .src_used(xm_op == OP_ST),
    .dst(mw_rd), .dst_live(mw_live), .hit(st_hit));

  always_comb begin
    fwd_a  = opnd_sel[0];
    fwd_b  = opnd_sel[1];
    fwd_st = BYPASS ? st_hit : 1'b0;
  end

  always_comb begin
    if (BYPASS && fd_op == OP_ST && dx_op == OP_LD && fd_rs2 == dx_rd && fd_rs1 != dx_rd)
      AST_STORE_DATA_WAIVED: assert (!stall);                               // R1
    if (BYPASS && dx_op != OP_NOP && xm_op == OP_ALU && xm_rd != '0 && dx_rs1 == xm_rd)
      AST_XM_WINS_A: assert (fwd_a == SEL_XM);                              // R3
    if (dx_rs1 == '0)
      AST_R0_NEVER_FWD_A: assert (fwd_a == SEL_RF);                         // R6
    if (fd_op == OP_NOP)
      AST_BUBBLE_NO_STALL: assert (!stall);                                 // R6
    if (!BYPASS)
      AST_LOCK_NO_FWD: assert (fwd_a == SEL_RF && fwd_b == SEL_RF && !fwd_st); // R7
    if (dx_op == OP_NOP && xm_op == OP_NOP)
      AST_MW_NO_STALL: assert (!stall);                                     // R9
  end
endmodule

// File: tb/hz_ctrl_bench.sv
module hz_ctrl_bench;
  localparam int NPROG = 80;
  localparam int NCYC  = 170;
  localparam logic [1:0] NOP = 2'b00, ALU = 2'b01, LD = 2'b10, ST = 2'b11;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;   // 50 MHz

  // lane 0: BYPASS=1, lane 1: BYPASS=0; stage 0 F/D, 1 D/X, 2 X/M, 3 M/W
  logic [1:0] sop [2][4];
  logic [4:0] sr1 [2][4];
  logic [4:0] sr2 [2][4];
  logic [4:0] srd [2][4];
  int         pc  [2];
  logic       estall [2];

  logic [1:0] p_op [NPROG];
  logic [4:0] p_r1 [NPROG], p_r2 [NPROG], p_rd [NPROG];

  logic       st0, st1, fs0, fs1;
  logic [1:0] fa0, fa1, fb0, fb1;

  int nchk = 0, nfail = 0, dut_stalls = 0, deps = 0;
  logic prev_stall = 1'b0;
  logic [1:0] ret_op = NOP;
  logic [4:0] ret_rd = '0;

  hz_ctrl #(.REG_W(5), .BYPASS(1'b1)) u_hz_ctrl (
    .fd_op(sop[0][0]), .fd_rs1(sr1[0][0]), .fd_rs2(sr2[0][0]),
    .dx_op(sop[0][1]), .dx_rs1(sr1[0][1]), .dx_rs2(sr2[0][1]), .dx_rd(srd[0][1]),
    .xm_op(sop[0][2]), .xm_rs2(sr2[0][2]), .xm_rd(srd[0][2]),
    .mw_op(sop[0][3]), .mw_rd(srd[0][3]),
    .stall(st0), .fwd_a(fa0), .fwd_b(fb0), .fwd_st(fs0));

  hz_ctrl #(.REG_W(5), .BYPASS(1'b0)) u_hz_ctrl_lock (
    .fd_op(sop[1][0]), .fd_rs1(sr1[1][0]), .fd_rs2(sr2[1][0]),
    .dx_op(sop[1][1]), .dx_rs1(sr1[1][1]), .dx_rs2(sr2[1][1]), .dx_rd(srd[1][1]),
    .xm_op(sop[1][2]), .xm_rs2(sr2[1][2]), .xm_rd(srd[1][2]),
    .mw_op(sop[1][3]), .mw_rd(srd[1][3]),
    .stall(st1), .fwd_a(fa1), .fwd_b(fb1), .fwd_st(fs1));

  function automatic bit live(input logic [1:0] op, input logic [4:0] rd);
    return (op == ALU || op == LD) && rd != 0;
  endfunction
  function automatic bit use1(input logic [1:0] op);
    return op != NOP;
  endfunction
  function automatic bit use2(input logic [1:0] op);
    return op == ALU || op == ST;
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic put(input int i, input logic [1:0] o, input int a, input int b, input int d);
    p_op[i] = o; p_r1[i] = 5'(a); p_r2[i] = 5'(b); p_rd[i] = 5'(d);
  endtask

  task automatic compare_lane(input int l);
    bit byp;
    logic es, ees;
    int ea, eb;
    byp = (l == 0);
    es = 0;
    if (byp) begin
      if (sop[l][1] == LD && live(sop[l][1], srd[l][1]) &&
          ((use1(sop[l][0]) && sr1[l][0] == srd[l][1]) ||
           (sop[l][0] == ALU && sr2[l][0] == srd[l][1])))
        es = 1;
    end else begin
      for (int k = 1; k <= 2; k++)
        if (live(sop[l][k], srd[l][k]) &&
            ((use1(sop[l][0]) && sr1[l][0] == srd[l][k]) ||
             (use2(sop[l][0]) && sr2[l][0] == srd[l][k])))
          es = 1;
    end
    ea = 2; eb = 2;
    if (byp) begin
      if (use1(sop[l][1]) && sop[l][2] == ALU && srd[l][2] != 0 && sr1[l][1] == srd[l][2]) ea = 0;
      else if (use1(sop[l][1]) && live(sop[l][3], srd[l][3]) && sr1[l][1] == srd[l][3]) ea = 1;
      if (use2(sop[l][1]) && sop[l][2] == ALU && srd[l][2] != 0 && sr2[l][1] == srd[l][2]) eb = 0;
      else if (use2(sop[l][1]) && live(sop[l][3], srd[l][3]) && sr2[l][1] == srd[l][3]) eb = 1;
    end
    ees = byp && sop[l][2] == ST && live(sop[l][3], srd[l][3]) && sr2[l][2] == srd[l][3];
    estall[l] = es;
    if (byp) begin
      chk(int'(st0), int'(es),  "R1 stall (bypass mode)");
      chk(int'(fa0), ea,        "R3 fwd_a");
      chk(int'(fb0), eb,        "R4 fwd_b");
      chk(int'(fs0), int'(ees), "R5 fwd_st");
    end else begin
      chk(int'(st1), int'(es),  "R2 stall (interlock mode)");
      chk(int'(fa1), ea,        "R7 fwd_a");
      chk(int'(fb1), eb,        "R7 fwd_b");
      chk(int'(fs1), int'(ees), "R7 fwd_st");
    end
  endtask

  task automatic advance(input int l);
    if (l == 0 && sop[0][3] != NOP) begin
      // retirement order equals program order: count load-use pairs (R8)
      if (ret_op == LD && ret_rd != 0 &&
          ((use1(sop[0][3]) && sr1[0][3] == ret_rd) || (sop[0][3] == ALU && sr2[0][3] == ret_rd)))
        deps++;
      ret_op = sop[0][3]; ret_rd = srd[0][3];
    end
    for (int k = 3; k >= 2; k--) begin
      sop[l][k] = sop[l][k-1]; sr1[l][k] = sr1[l][k-1];
      sr2[l][k] = sr2[l][k-1]; srd[l][k] = srd[l][k-1];
    end
    if (estall[l]) begin
      sop[l][1] = NOP; sr1[l][1] = '0; sr2[l][1] = '0; srd[l][1] = '0;
    end else begin
      sop[l][1] = sop[l][0]; sr1[l][1] = sr1[l][0];
      sr2[l][1] = sr2[l][0]; srd[l][1] = srd[l][0];
      if (pc[l] < NPROG) begin
        sop[l][0] = p_op[pc[l]]; sr1[l][0] = p_r1[pc[l]];
        sr2[l][0] = p_r2[pc[l]]; srd[l][0] = p_rd[pc[l]];
      end else begin
        sop[l][0] = NOP; sr1[l][0] = '0; sr2[l][0] = '0; srd[l][0] = '0;
      end
      pc[l]++;
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    logic [15:0] lf;
    // directed pairs
    put(0,  LD,  4, 0, 1);
    put(1,  ALU, 1, 5, 2);   // R1 load-use on source 1
    put(2,  LD,  2, 0, 3);
    put(3,  ST,  6, 3, 0);   // R1 waiver, R5 store-data bypass
    put(4,  LD,  0, 0, 7);
    put(5,  ST,  7, 8, 0);   // R1 address needs load: stall
    put(6,  LD,  1, 0, 0);   // R6 load into r0
    put(7,  ALU, 0, 0, 9);   // R6 reads r0: no stall, no forward
    put(8,  ALU, 9, 9, 10);
    put(9,  ALU, 1, 2, 10);
    put(10, ALU, 10, 10, 11); // R3 X/M beats M/W
    put(11, LD,  3, 0, 12);
    put(12, ALU, 5, 12, 13);  // R1 load-use on source 2
    put(13, LD,  1, 0, 14);
    put(14, LD,  14, 0, 15);  // load address from load
    lf = 16'hACE1;
    for (int i = 15; i < NPROG; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      put(i, 2'(1 + (lf % 3)), int'(lf[5:4]), int'(lf[7:6]), int'(lf[9:8]));
    end
    for (int l = 0; l < 2; l++) begin
      pc[l] = 0; estall[l] = 0;
      for (int k = 0; k < 4; k++) begin
        sop[l][k] = NOP; sr1[l][k] = '0; sr2[l][k] = '0; srd[l][k] = '0;
      end
    end
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      compare_lane(0);   // R9 reset state: all bubbles
      compare_lane(1);
    end
    @(posedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      @(posedge clk);
      advance(0);
      advance(1);
      @(negedge clk);
      compare_lane(0);
      compare_lane(1);
      if (st0) dut_stalls++;
      nchk++;
      if (st0 && prev_stall) begin
        nfail++;
        $display("FAIL R8 back-to-back stall actual=1 expected=0 at %0t", $time);
      end
      prev_stall = st0;
    end
    chk(dut_stalls, deps, "R8 stall cycles vs load-use pairs");
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end
endmodule